// File: doc/BRIEF.md
# Mode-selectable modulo-4 / modulo-3 counter

This block is a two-bit synchronous up-counter whose wrap point is chosen at run time by one input. With the mode input low it steps through every two-bit value and wraps from 3 to 0. With the mode input high it wraps after 2, so it runs through three values. A surrounding design can switch the counter between a four-phase and a three-phase rotation without stopping it.

The state sits in two JK storage cells: `a` holds the upper bit and `b` the lower bit. Their J and K inputs come from minimised equations. These equations assume that count 3 never meets mode high, and they use that combination as a don't-care. The don't-care is filled in a fixed way: when count 3 meets mode high anyway, the counter goes to 0. That outcome is part of the contract, so a user can rely on it.

Top module: `mod43_counter`

## Requirements
- R1: Reset is synchronous and active high. At a rising clock edge with `rst` = 1, `count` becomes 0 whatever `mode_short` is.
- R2: With `mode_short` = 0 and `rst` = 0, each rising edge moves `count` along 0 → 1 → 2 → 3 → 0.
- R3: With `mode_short` = 1 and `rst` = 0, each rising edge moves `count` along 0 → 1 → 2 → 0.
- R4: If `mode_short` = 1 while `count` = 3, the next rising edge sets `count` to 0.
- R5: The next value depends only on the `mode_short` level seen at that edge. A mode change made in the middle of a sequence takes effect at the very next edge.
- R6: `count` is a registered output. It does not change between rising edges, even when `mode_short` toggles inside a clock period.
- R7: While `rst` stays at 1 over several edges, `count` stays at 0. The first edge after release moves it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_short | input | 1 | 0: four-value cycle, 1: three-value cycle |
| count | output | 2 | Current count; bit 1 is cell A, bit 0 is cell B |

## Verification
On every cycle, the assertions check each single-step transition: the increments below 2, the wrap at 3 in long mode, the wrap at 2 in short mode, the forced exit from 3 in short mode, and reset to zero. Other behaviours only show up across a run of cycles: the full sequence under each mode, mode switches in the middle of a sequence, toggling of `mode_short` inside a clock period, and release from a long reset. The bench shows these by comparing against its own model at every cycle.

// File: rtl/mod43_pkg.sv
package mod43_pkg;
   localparam int CNT_W     = 2;
   localparam int CNT_MAX   = (1 << CNT_W) - 1;
   localparam int SHORT_TOP = CNT_MAX - 1;

   typedef enum int {
      CELL_CASE = 0,
      CELL_CHAR = 1
   } cell_style_e;

   typedef struct packed {
      logic j;
      logic k;
   } jk_pair_t;
endpackage

// File: rtl/mod43_jk_cell.sv
module mod43_jk_cell #(
   parameter int STYLE = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic j,
   input  logic k,
   output logic q
);
   import mod43_pkg::*;

   generate
      if (STYLE == CELL_CASE) begin : g_case
         always_ff @(posedge clk) begin
            if (rst) begin
               q <= 1'b0;
            end else begin
               unique case ({j, k})
                  2'b00:   q <= q;
                  2'b01:   q <= 1'b0;
                  2'b10:   q <= 1'b1;
                  default: q <= ~q;
               endcase
            end
         end
      end else if (STYLE == CELL_CHAR) begin : g_char
         logic d_next;
         assign d_next = (j & ~q) | (~k & q);
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= d_next;
         end
      end else begin : g_bad
         $error("mod43_jk_cell: STYLE must be CELL_CASE or CELL_CHAR");
      end
   endgenerate
endmodule

// File: rtl/mod43_excite.sv
module mod43_excite (
   input  logic                 a,
   input  logic                 b,
   input  logic                 x,
   output mod43_pkg::jk_pair_t  drv_a,
   output mod43_pkg::jk_pair_t  drv_b
);
   // Minimised with (x=1, a=1, b=1) taken as don't-care.
   // Its fill gives ka=1 and kb=1 there, so the next state is 00.
   always_comb begin
      drv_a.j = b;
      drv_a.k = x | b;
      drv_b.j = ~a | ~x;
      drv_b.k = 1'b1;
   end
endmodule

// File: rtl/mod43_counter.sv
module mod43_counter #(
   parameter int CELL_STYLE = 0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       mode_short,
   output logic [1:0] count
);
   import mod43_pkg::*;

   if (CNT_W != 2) begin : g_chk_w
      $error("mod43_counter: the JK equations are fixed to a two-bit state");
   end
   if (CELL_STYLE != CELL_CASE && CELL_STYLE != CELL_CHAR) begin : g_chk_s
      $error("mod43_counter: unknown CELL_STYLE");
   end

   logic     q_a;
   logic     q_b;
   jk_pair_t drv_a;
   jk_pair_t drv_b;

   mod43_excite u_excite (
      .a     (q_a),
      .b     (q_b),
      .x     (mode_short),
      .drv_a (drv_a),
      .drv_b (drv_b)
   );

   mod43_jk_cell #(.STYLE(CELL_STYLE)) u_cell_a (
      .clk (clk),
      .rst (rst),
      .j   (drv_a.j),
      .k   (drv_a.k),
      .q   (q_a)
   );

   mod43_jk_cell #(.STYLE(CELL_STYLE)) u_cell_b (
      .clk (clk),
      .rst (rst),
      .j   (drv_b.j),
      .k   (drv_b.k),
      .q   (q_b)
   );

   assign count = {q_a, q_b};

   AST_RESET_ZERO: assert property (@(posedge clk) rst |=> count == 2'd0); // R1
   AST_LOW_STEP: assert property (@(posedge clk) disable iff (rst)
      count < 2'(SHORT_TOP) |=> count == $past(count) + 2'd1); // R2
   AST_LONG_TWO: assert property (@(posedge clk) disable iff (rst)
      (count == 2'd2 && !mode_short) |=> count == 2'd3); // R2
   AST_LONG_WRAP: assert property (@(posedge clk) disable iff (rst)
      (count == 2'(CNT_MAX) && !mode_short) |=> count == 2'd0); // R2
   AST_SHORT_WRAP: assert property (@(posedge clk) disable iff (rst)
      (count == 2'(SHORT_TOP) && mode_short) |=> count == 2'd0); // R3
   AST_DC_EXIT: assert property (@(posedge clk) disable iff (rst)
      (count == 2'(CNT_MAX) && mode_short) |=> count == 2'd0); // R4
endmodule

// File: tb/mod43_counter_test.sv
module mod43_counter_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mode_short = 1'b0;
   logic [1:0] count;

   int n_run  = 0;
   int n_fail = 0;
   int model  = 0;

   always #10 clk = ~clk;

   mod43_counter uut (
      .clk        (clk),
      .rst        (rst),
      .mode_short (mode_short),
      .count      (count)
   );

   function automatic int ref_next(int cur, bit r, bit m);
      if (r) return 0;
      if (m) return (cur >= 2) ? 0 : cur + 1;
      return (cur + 1) % 4;
   endfunction

   task automatic check(string req, int exp);
      n_run++;
      if (int'(count) != exp) begin
         n_fail++;
         $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
      end
   endtask

   // drive at a falling edge, compare at the next falling edge
   task automatic step(bit r, bit m, string req);
      rst = r;
      mode_short = m;
      model = ref_next(model, r, m);
      @(negedge clk);
      check(req, model);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      step(1'b1, 1'b0, "R1");
      check("R1 reset state", 0);
      step(1'b1, 1'b1, "R1 reset with mode high");
      // R2 full cycle, twice
      for (int i = 0; i < 8; i++) step(1'b0, 1'b0, "R2");
      // R3 short cycle, three rounds
      for (int i = 0; i < 9; i++) step(1'b0, 1'b1, "R3");
      // R4: reach 3 in long mode, then raise the mode
      step(1'b0, 1'b0, "R2");
      step(1'b0, 1'b0, "R2");
      step(1'b0, 1'b0, "R2");
      check("R4 setup at 3", 3);
      step(1'b0, 1'b1, "R4");
      check("R4 exit to zero", 0);
      // R5: mode flips in the middle of a sequence
      step(1'b0, 1'b0, "R5");
      step(1'b0, 1'b1, "R5");
      step(1'b0, 1'b0, "R5");
      step(1'b0, 1'b0, "R5");
      step(1'b0, 1'b1, "R5");
      step(1'b0, 1'b0, "R5");
      step(1'b0, 1'b1, "R5");
      step(1'b0, 1'b1, "R5");
      for (int i = 0; i < 12; i++) step(1'b0, 1'((i * 7 + 3) % 5 < 2), "R5");
      // R6: toggle the mode during the low phase, count must hold
      for (int i = 0; i < 4; i++) begin
         mode_short = ~mode_short;
         #3 check("R6 hold", model);
         mode_short = ~mode_short;
         #3 check("R6 hold", model);
         @(negedge clk);
         model = ref_next(model, 1'b0, mode_short);
         check("R6", model);
      end
      // R7: long reset, then release
      for (int i = 0; i < 4; i++) step(1'b1, 1'(i % 2), "R7 held");
      step(1'b0, 1'b0, "R7 release");
      check("R7 first count", 1);
      // R1 in the middle of a count
      step(1'b0, 1'b0, "R2");
      step(1'b1, 1'b0, "R1 mid-count");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule